// File: doc/BRIEF.md
# Radix-Adjusted Subtract-With-Borrow Unit

This block executes one family of 4-bit arithmetic instructions. Each one subtracts a memory nibble and the incoming carry from an accumulator, then corrects the difference into a radix from 1 to 16 that the opcode carries. The unit owns the accumulator, the carry and zero flags, and two 16-bit index registers. It fetches its operand through a single synchronous read port that returns data one cycle after the address.

Each instruction picks one of the two index registers as the operand pointer and may increment that pointer afterwards. A one-shot page prefix can be armed before an instruction that does not increment. While the prefix is pending, that instruction's operand address is replaced by an 8-bit offset on a fixed page: the low page for the first index register and the top page for the second. Around the unit, a sequencer supplies opcodes, arms the prefix and loads registers through a direct write port.

Top module: `radix_sbc_unit`

## Requirements
- R1: An opcode is accepted when bits 12..6 equal 1110011. Bit 5 selects the index register (0 = X, 1 = Y). Bit 4 selects post-increment (1 = increment). Bits 3..0 hold the radix code.
- R2: The new accumulator comes from d = B − M − C, where M is the memory nibble and C is the old carry. If d < 0, the result is (d + n) mod 16 and the carry becomes 1. Otherwise the result is d and the carry becomes 0.
- R3: A radix code of 0000 means radix 16. Any other code k means radix k.
- R4: The zero flag is 1 exactly when the new 4-bit accumulator is 0. The zero flag is not affected by the index increment.
- R5: With no prefix pending, the operand address is the selected index register. The read strobe is high for exactly the one cycle after the opcode is accepted.
- R6: With a prefix pending, a non-increment form reads from address 0x00 followed by the 8-bit offset when it uses X, and from 0xFF followed by the offset when it uses Y.
- R7: A post-increment form ignores any pending prefix and reads at the index register. It then adds 1 to that register, modulo 2^16.
- R8: Completing any instruction of the family clears a pending prefix.
- R9: The busy output is high for two cycles after acceptance. The results are visible in the cycle after that. A start request while busy is ignored.
- R10: An opcode outside the family raises the illegal output for one cycle. It leaves the accumulator, flags and index registers unchanged, performs no read, and keeps a pending prefix.
- R11: After reset, B, C, Z, X and Y are zero, busy, illegal and the read strobe are low, and no prefix is pending.
- R12: While idle with no start request, the write port loads B, C, X and Y in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to execute opcode_i |
| opcode_i | input | 13 | Instruction word |
| ext_set_i | input | 1 | Arm the one-shot page prefix |
| ext_imm_i | input | 8 | Page offset for the prefix |
| wr_en_i | input | 1 | Direct register load strobe |
| wr_b_i | input | 4 | Accumulator load value |
| wr_c_i | input | 1 | Carry load value |
| wr_x_i | input | 16 | X load value |
| wr_y_i | input | 16 | Y load value |
| mem_rdata_i | input | 4 | Read data, valid one cycle after the strobe |
| mem_rd_en_o | output | 1 | Read strobe |
| mem_addr_o | output | 16 | Read address |
| b_o | output | 4 | Accumulator |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| x_o | output | 16 | Index register X |
| y_o | output | 16 | Index register Y |
| busy_o | output | 1 | Instruction in progress |
| illegal_o | output | 1 | One-cycle pulse for an unknown opcode |

## Verification
The hardest cases to reach are those that depend on the prefix, because its pending state is never visible at the ports. Only the address of a later read reveals it. The bench arms the prefix and then issues sequences that should consume it, ignore it, or keep it: an increment form, an illegal opcode, and a non-increment form. After each sequence it checks the captured read address. The arithmetic is covered by a full sweep of radix code, accumulator, memory nibble and carry, with the operand nibble steered through the index value.

// File: rtl/radix_sbc_pkg.sv
package radix_sbc_pkg;
  localparam int OPC_W   = 13;
  localparam int FAM_W   = 7;
  localparam logic [FAM_W-1:0] FAM_CODE = 7'b1110011;
  localparam int SEL_BIT = 5;
  localparam int INC_BIT = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WB   = 2'd2
  } sbc_state_e;
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import radix_sbc_pkg::*;
#(
  parameter int RAD_W = 4
) (
  input  logic [OPC_W-1:0] opcode,
  output logic             legal,
  output logic             sel_y,
  output logic             post_inc,
  output logic [RAD_W-1:0] radix_code
);
  always_comb begin
    legal      = (opcode[OPC_W-1 -: FAM_W] == FAM_CODE);
    sel_y      = opcode[SEL_BIT];
    post_inc   = opcode[INC_BIT];
    radix_code = opcode[RAD_W-1:0];
  end
endmodule

// File: rtl/sbc_addr_gen.sv
module sbc_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 8
) (
  input  logic [ADDR_W-1:0] x_val,
  input  logic [ADDR_W-1:0] y_val,
  input  logic              sel_y,
  input  logic              post_inc,
  input  logic              ext_pend,
  input  logic [EXT_W-1:0]  ext_imm,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAGE_W = ADDR_W - EXT_W;

  logic [ADDR_W-1:0] idx_addr;
  logic [ADDR_W-1:0] page_addr;

  always_comb begin
    idx_addr  = sel_y ? y_val : x_val;
    page_addr = {{PAGE_W{sel_y}}, ext_imm};
    addr      = (ext_pend && !post_inc) ? page_addr : idx_addr;
  end
endmodule

// File: rtl/sbc_radix_alu.sv
module sbc_radix_alu #(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] m,
  input  logic              cin,
  input  logic [DATA_W-1:0] radix_code,
  output logic [DATA_W-1:0] res,
  output logic              borrow,
  output logic              zero
);
  localparam int EW = DATA_W + 2;

  logic signed [EW-1:0] diff;
  logic signed [EW-1:0] radix;
  logic signed [EW-1:0] wrapped;

  always_comb begin
    radix   = (radix_code == '0) ? EW'(1 << DATA_W) : $signed({2'b00, radix_code});
    diff    = $signed({2'b00, a}) - $signed({2'b00, m}) - $signed({{(EW-1){1'b0}}, cin});
    borrow  = diff[EW-1];
    wrapped = diff + radix;
    res     = borrow ? wrapped[DATA_W-1:0] : diff[DATA_W-1:0];
    zero    = (res == '0);
  end
endmodule

// File: rtl/radix_sbc_unit.sv
module radix_sbc_unit
  import radix_sbc_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [12:0]       opcode_i,
  input  logic              ext_set_i,
  input  logic [EXT_W-1:0]  ext_imm_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_b_i,
  input  logic              wr_c_i,
  input  logic [ADDR_W-1:0] wr_x_i,
  input  logic [ADDR_W-1:0] wr_y_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] b_o,
  output logic              c_o,
  output logic              z_o,
  output logic [ADDR_W-1:0] x_o,
  output logic [ADDR_W-1:0] y_o,
  output logic              busy_o,
  output logic              illegal_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  sbc_state_e        state_q;
  logic [DATA_W-1:0] b_q;
  logic              c_q, z_q;
  logic [ADDR_W-1:0] x_q, y_q;
  logic              ext_pend_q;
  logic [EXT_W-1:0]  ext_imm_q;
  logic              op_sel_y_q, op_inc_q;
  logic [DATA_W-1:0] op_radix_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic              mem_rd_q;
  logic              illegal_q;

  logic              dec_legal, dec_sel_y, dec_inc;
  logic [DATA_W-1:0] dec_radix;
  logic [ADDR_W-1:0] gen_addr;
  logic [DATA_W-1:0] alu_res;
  logic              alu_borrow, alu_zero;
  logic              idle;

  sbc_decode #(.RAD_W(DATA_W)) u_decode (
    .opcode     (opcode_i),
    .legal      (dec_legal),
    .sel_y      (dec_sel_y),
    .post_inc   (dec_inc),
    .radix_code (dec_radix)
  );

  sbc_addr_gen #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_addr (
    .x_val    (x_q),
    .y_val    (y_q),
    .sel_y    (dec_sel_y),
    .post_inc (dec_inc),
    .ext_pend (ext_pend_q),
    .ext_imm  (ext_imm_q),
    .addr     (gen_addr)
  );

  sbc_radix_alu #(.DATA_W(DATA_W)) u_alu (
    .a          (b_q),
    .m          (mem_rdata_i),
    .cin        (c_q),
    .radix_code (op_radix_q),
    .res        (alu_res),
    .borrow     (alu_borrow),
    .zero       (alu_zero)
  );

  assign idle = (state_q == ST_IDLE);

  // Sequencer: accept, read, write back
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      op_sel_y_q <= 1'b0;
      op_inc_q   <= 1'b0;
      op_radix_q <= '0;
      mem_addr_q <= '0;
      mem_rd_q   <= 1'b0;
      illegal_q  <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      mem_rd_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (dec_legal) begin
              op_sel_y_q <= dec_sel_y;
              op_inc_q   <= dec_inc;
              op_radix_q <= dec_radix;
              mem_addr_q <= gen_addr;
              mem_rd_q   <= 1'b1;
              state_q    <= ST_RD;
            end else begin
              illegal_q  <= 1'b1;
            end
          end
        end
        ST_RD:   state_q <= ST_WB;
        ST_WB:   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Architectural state
  always_ff @(posedge clk) begin
    if (rst) begin
      b_q        <= '0;
      c_q        <= 1'b0;
      z_q        <= 1'b0;
      x_q        <= '0;
      y_q        <= '0;
      ext_pend_q <= 1'b0;
      ext_imm_q  <= '0;
    end else if (state_q == ST_WB) begin
      b_q        <= alu_res;
      c_q        <= alu_borrow;
      z_q        <= alu_zero;
      ext_pend_q <= 1'b0;
      if (op_inc_q) begin
        if (op_sel_y_q) y_q <= y_q + ONE;
        else            x_q <= x_q + ONE;
      end
    end else if (idle && !start_i) begin
      if (wr_en_i) begin
        b_q <= wr_b_i;
        c_q <= wr_c_i;
        x_q <= wr_x_i;
        y_q <= wr_y_i;
      end
      if (ext_set_i) begin
        ext_pend_q <= 1'b1;
        ext_imm_q  <= ext_imm_i;
      end
    end
  end

  assign mem_rd_en_o = mem_rd_q;
  assign mem_addr_o  = mem_addr_q;
  assign b_o         = b_q;
  assign c_o         = c_q;
  assign z_o         = z_q;
  assign x_o         = x_q;
  assign y_o         = y_q;
  assign busy_o      = !idle;
  assign illegal_o   = illegal_q;

  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    mem_rd_q |=> !mem_rd_q);

  assert_two_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RD) |=> (state_q == ST_WB));

  assert_illegal_no_change_R10: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> (b_q == $past(b_q) && x_q == $past(x_q) && y_q == $past(y_q) && !mem_rd_q));

  assert_inc_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WB && op_inc_q && !op_sel_y_q) |=> (x_q == $past(x_q) + ONE));

  assert_prefix_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WB) |=> !ext_pend_q);

  assert_page_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RD && ext_pend_q && !op_inc_q) |-> (mem_addr_q[EXT_W-1:0] == ext_imm_q));

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WB) |=> (z_q == (b_q == '0)));
endmodule

// File: tb/radix_sbc_unit_test.sv
`timescale 1ns/1ps
module radix_sbc_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i = 1'b0;
  logic [12:0] opcode_i = '0;
  logic        ext_set_i = 1'b0;
  logic [7:0]  ext_imm_i = '0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_b_i = '0;
  logic        wr_c_i = 1'b0;
  logic [15:0] wr_x_i = '0, wr_y_i = '0;
  logic [3:0]  mem_rdata_i = '0;
  logic        mem_rd_en_o;
  logic [15:0] mem_addr_o;
  logic [3:0]  b_o;
  logic        c_o, z_o;
  logic [15:0] x_o, y_o;
  logic        busy_o, illegal_o;

  int errors = 0;
  int checks = 0;
  int rd_count = 0;
  logic [15:0] last_addr = '0;

  always #2 clk = ~clk;

  radix_sbc_unit uut (.*);

  function automatic logic [3:0] mem_fn(logic [15:0] a);
    return a[3:0] ^ a[7:4] ^ a[11:8] ^ a[15:12];
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en_o) begin
      mem_rdata_i <= mem_fn(mem_addr_o);
      last_addr   <= mem_addr_o;
      rd_count    <= rd_count + 1;
    end
  end

  function automatic logic [12:0] opc(logic sy, logic inc, logic [3:0] code);
    return {7'b1110011, sy, inc, code};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] b, input logic c, input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    wr_en_i = 1'b1; wr_b_i = b; wr_c_i = c; wr_x_i = x; wr_y_i = y;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic arm(input logic [7:0] imm);
    @(negedge clk);
    ext_set_i = 1'b1; ext_imm_i = imm;
    @(negedge clk);
    ext_set_i = 1'b0;
  endtask

  // issue and wait until results are visible
  task automatic run(input logic [12:0] op);
    start_i = 1'b1; opcode_i = op;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_op(input int b, input int m, input int c, input int code,
                           output logic [3:0] r, output logic cf);
    int n, d;
    n = (code == 0) ? 16 : code;
    d = b - m - c;
    cf = (d < 0);
    r = cf ? 4'((d + n) & 15) : 4'(d & 15);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] er;
    logic ec;
    int rc0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(b_o == 0 && c_o == 0 && z_o == 0 && x_o == 0 && y_o == 0, "R11 reset regs",
        {b_o, c_o, z_o, x_o}, 0);
    chk(!busy_o && !illegal_o && !mem_rd_en_o, "R11 reset ctrl", {busy_o, illegal_o, mem_rd_en_o}, 0);

    // R12 load port
    load(4'h9, 1'b1, 16'h1234, 16'hABCD);
    chk(b_o == 9 && c_o && x_o == 16'h1234 && y_o == 16'hABCD, "R12 load", {b_o, x_o}, 20'h91234);

    // R1 R2 R3 R4 exhaustive sweep
    for (int code = 0; code < 16; code++)
      for (int b = 0; b < 16; b++)
        for (int m = 0; m < 16; m++)
          for (int c = 0; c < 2; c++) begin
            logic [15:0] a;
            logic sy;
            a  = {4'(code), 4'(b), 4'(code ^ b), 4'(m)};
            sy = m[0] ^ c[0];
            load(4'(b), c[0], a, a);
            run(opc(sy, 1'b0, 4'(code)));
            expect_op(b, int'(mem_fn(a)), c, code, er, ec);
            chk(b_o == er && c_o == ec && z_o == (er == 0), "R2 R3 R4 sweep",
                {b_o, c_o, z_o}, {er, ec, er == 0});
          end

    // R5 R9 timing and address
    load(4'h3, 1'b0, 16'h4321, 16'h0F0F);
    rc0 = rd_count;
    start_i = 1'b1; opcode_i = opc(1'b0, 1'b0, 4'd10);
    @(negedge clk);
    chk(busy_o && mem_rd_en_o && mem_addr_o == 16'h4321, "R5 strobe addr", mem_addr_o, 16'h4321);
    opcode_i = opc(1'b1, 1'b1, 4'd10); // held start while busy
    @(negedge clk);
    chk(busy_o && !mem_rd_en_o, "R9 busy second cycle", {busy_o, mem_rd_en_o}, 2'b10);
    start_i = 1'b0;
    @(negedge clk);
    chk(!busy_o && rd_count == rc0 + 1 && y_o == 16'h0F0F, "R9 start while busy ignored",
        rd_count - rc0, 1);
    expect_op(3, int'(mem_fn(16'h4321)), 0, 10, er, ec);
    chk(b_o == er && c_o == ec, "R9 result after two cycles", b_o, er);

    // R7 post-increment and wrap, Z from result
    load(4'h0, 1'b0, 16'hFFFF, 16'h0010);
    run(opc(1'b0, 1'b1, 4'd0));
    expect_op(0, int'(mem_fn(16'hFFFF)), 0, 0, er, ec);
    chk(x_o == 16'h0000 && last_addr == 16'hFFFF, "R7 X wrap", x_o, 0);
    chk(b_o == er && z_o == (er == 0) && c_o == ec, "R4 flags on inc form", {b_o, z_o}, {er, er == 0});
    run(opc(1'b1, 1'b1, 4'd7));
    chk(y_o == 16'h0011 && last_addr == 16'h0010 && x_o == 0, "R7 Y inc", y_o, 16'h0011);

    // R6 page prefix
    load(4'h8, 1'b0, 16'h2222, 16'h3333);
    arm(8'h37);
    run(opc(1'b0, 1'b0, 4'd9));
    chk(last_addr == 16'h0037, "R6 X page", last_addr, 16'h0037);
    // R8 prefix consumed
    run(opc(1'b0, 1'b0, 4'd9));
    chk(last_addr == 16'h2222, "R8 prefix cleared", last_addr, 16'h2222);
    arm(8'hC5);
    run(opc(1'b1, 1'b0, 4'd5));
    chk(last_addr == 16'hFFC5, "R6 Y page", last_addr, 16'hFFC5);

    // R7 inc form ignores prefix, and R8 clears it
    arm(8'h11);
    run(opc(1'b0, 1'b1, 4'd4));
    chk(last_addr == 16'h2222 && x_o == 16'h2223, "R7 prefix ignored", last_addr, 16'h2222);
    run(opc(1'b1, 1'b0, 4'd4));
    chk(last_addr == 16'h3333, "R8 cleared by inc form", last_addr, 16'h3333);

    // R10 illegal opcode
    load(4'h6, 1'b1, 16'h5555, 16'h6666);
    arm(8'h44);
    rc0 = rd_count;
    start_i = 1'b1; opcode_i = 13'h1C00;
    @(negedge clk);
    start_i = 1'b0;
    chk(illegal_o && !busy_o && !mem_rd_en_o, "R10 illegal pulse", {illegal_o, busy_o}, 2'b10);
    @(negedge clk);
    chk(!illegal_o && b_o == 6 && c_o && x_o == 16'h5555 && y_o == 16'h6666 && rd_count == rc0,
        "R10 no change", {illegal_o, b_o}, 6);
    start_i = 1'b1; opcode_i = 13'h1D3A;
    @(negedge clk);
    start_i = 1'b0;
    chk(illegal_o, "R1 outside family rejected", illegal_o, 1);
    @(negedge clk);
    run(opc(1'b1, 1'b0, 4'd3));
    chk(last_addr == 16'hFF44, "R10 prefix kept", last_addr, 16'hFF44);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule